// File: doc/BRIEF.md
# Dual-Channel Address Sequencer

This block holds two independent address pointers. Each pointer serves one data bus of a signal-processing datapath and yields one address for every request it accepts. Every channel is set up once through its configuration inputs: an initial address, a signed increment, a lower and an upper buffer limit, and an addressing mode. After that setup, one request pulse per cycle walks the pointer through a linear, circular or bit-reversed sequence.

There are four modes. Linear mode with update after use returns the pointer and then adds the increment. Linear mode with update before use adds the increment first and returns the new value. Circular mode keeps the pointer inside an arbitrary inclusive window and folds any overshoot back in from the opposite limit. Reverse-carry mode adds the increment with carries that run from the most significant bit toward the least significant bit. With an increment of half the transform size, this gives the permuted order used in FFTs.

Top module: `dual_agu`

## Requirements
- R1: While reset is held, and in the first cycle after it, every `addr` lane reads zero and every `addr_vld` bit reads zero.
- R2: Mode code 0 (linear, update after use): a request outputs the current pointer. The pointer then becomes pointer + increment, modulo 2^AW, and the increment may be negative in two's complement.
- R3: Mode code 1 (linear, update before use): a request sets the pointer to pointer + increment, modulo 2^AW, and outputs that new value.
- R4: Mode code 2 (circular, update after use): a request outputs the pointer. If pointer + increment exceeds the upper limit, the next pointer is lower limit + (sum − upper limit − 1).
- R5: In mode code 2, if pointer + increment falls below the lower limit, the next pointer is upper limit − (lower limit − sum − 1). This handles negative increments whose magnitude is at most the window length.
- R6: Mode code 3 (reverse-carry, update after use): a request outputs the pointer. The next pointer is the sum of pointer and increment with carries running from bit AW−1 toward bit 0, and the carry out of bit 0 is dropped.
- R7: A configuration write to a channel loads all of its settings and reloads its pointer from the initial address. The first request after the write uses that reloaded pointer.
- R8: A request that arrives in the same cycle as a configuration write to the same channel is dropped. In the next cycle that channel's `addr_vld` is 0 and its `addr` is unchanged.
- R9: Both channels may accept requests in the same cycle. Each produces exactly the result it would produce alone, and a request on one channel leaves the other channel's output untouched.
- R10: `addr_vld` goes high in the cycle after an accepted request and low in the cycle after any cycle without one. `addr` changes only when `addr_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | NUNITS | Per-channel configuration write strobe |
| cfg_mode | input | NUNITS×2 | Mode code per channel (0..3) |
| cfg_base | input | NUNITS×AW | Initial pointer per channel |
| cfg_step | input | NUNITS×AW | Signed increment per channel |
| cfg_lo | input | NUNITS×AW | Circular window lower limit (inclusive) |
| cfg_hi | input | NUNITS×AW | Circular window upper limit (inclusive) |
| req | input | NUNITS | Per-channel address request |
| addr | output | NUNITS×AW | Registered address per channel |
| addr_vld | output | NUNITS | Address valid, one cycle after an accepted request |

## Verification
Two kinds of event can share a clock edge. The first is a request on each channel in the same cycle. The bench fires both channels in one cycle with different modes and signs of increment, checks both results, and then checks that a lone request on one channel leaves the other's output alone. The second is a configuration write together with a request on the same channel. The bench drives both together and checks that the valid flag stays low and the old address holds. It then checks that the following request returns the reloaded initial address.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      AGU_POST = 2'd0,
      AGU_PRE  = 2'd1,
      AGU_CIRC = 2'd2,
      AGU_REV  = 2'd3
   } agu_mode_e;
endpackage

// File: rtl/agu_revadd.sv
// Adder whose carry chain runs from the MSB toward the LSB.
module agu_revadd #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   output logic [AW-1:0] y
);
   logic [AW-1:0] a_r, b_r, s_r;

   for (genvar i = 0; i < AW; i++) begin : g_flip
      assign a_r[i] = a[AW-1-i];
      assign b_r[i] = b[AW-1-i];
      assign y[i]   = s_r[AW-1-i];
   end

   assign s_r = a_r + b_r;
endmodule

// File: rtl/agu_circ.sv
// Circular-window next-pointer computation over an inclusive [lo, hi] window.
module agu_circ #(
   parameter int AW = 16
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic [AW-1:0] nxt
);
   localparam int EW = AW + 2;

   logic signed [EW-1:0] sum, len, lo_x, hi_x, res;

   always_comb begin
      lo_x = $signed({2'b00, lo});
      hi_x = $signed({2'b00, hi});
      len  = hi_x - lo_x + EW'(1);
      sum  = $signed({2'b00, ptr}) + $signed({{2{step[AW-1]}}, step});
      if (sum > hi_x)      res = sum - len;
      else if (sum < lo_x) res = sum + len;
      else                 res = sum;
      nxt = res[AW-1:0];
   end
endmodule

// File: rtl/agu_unit.sv
module agu_unit
   import agu_pkg::*;
#(
   parameter int AW      = 16,
   parameter bit HAS_REV = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [1:0]    cfg_mode,
   input  logic [AW-1:0] cfg_base,
   input  logic [AW-1:0] cfg_step,
   input  logic [AW-1:0] cfg_lo,
   input  logic [AW-1:0] cfg_hi,
   input  logic          req,
   output logic [AW-1:0] addr,
   output logic          addr_vld
);
   agu_mode_e     mode_q;
   logic [AW-1:0] ptr_q, step_q, lo_q, hi_q;
   logic [AW-1:0] lin_nxt, circ_nxt, rev_nxt;
   logic [AW-1:0] out_val, ptr_nxt;

   assign lin_nxt = ptr_q + step_q;

   agu_circ #(.AW(AW)) u_circ (
      .ptr (ptr_q),
      .step(step_q),
      .lo  (lo_q),
      .hi  (hi_q),
      .nxt (circ_nxt)
   );

   if (HAS_REV) begin : g_rev
      agu_revadd #(.AW(AW)) u_rev (
         .a(ptr_q),
         .b(step_q),
         .y(rev_nxt)
      );
   end else begin : g_norev
      assign rev_nxt = lin_nxt;
   end

   always_comb begin
      unique case (mode_q)
         AGU_PRE:  begin out_val = lin_nxt; ptr_nxt = lin_nxt;  end
         AGU_CIRC: begin out_val = ptr_q;   ptr_nxt = circ_nxt; end
         AGU_REV:  begin out_val = ptr_q;   ptr_nxt = rev_nxt;  end
         default:  begin out_val = ptr_q;   ptr_nxt = lin_nxt;  end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= AGU_POST;
         ptr_q    <= '0;
         step_q   <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         addr     <= '0;
         addr_vld <= 1'b0;
      end else if (cfg_wr) begin
         mode_q   <= agu_mode_e'(cfg_mode);
         ptr_q    <= cfg_base;
         step_q   <= cfg_step;
         lo_q     <= cfg_lo;
         hi_q     <= cfg_hi;
         addr_vld <= 1'b0;
      end else if (req) begin
         ptr_q    <= ptr_nxt;
         addr     <= out_val;
         addr_vld <= 1'b1;
      end else begin
         addr_vld <= 1'b0;
      end
   end
endmodule

// File: rtl/dual_agu.sv
module dual_agu #(
   parameter int AW      = 16,
   parameter int NUNITS  = 2,
   parameter bit HAS_REV = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUNITS-1:0]            cfg_wr,
   input  logic [NUNITS-1:0][1:0]       cfg_mode,
   input  logic [NUNITS-1:0][AW-1:0]    cfg_base,
   input  logic [NUNITS-1:0][AW-1:0]    cfg_step,
   input  logic [NUNITS-1:0][AW-1:0]    cfg_lo,
   input  logic [NUNITS-1:0][AW-1:0]    cfg_hi,
   input  logic [NUNITS-1:0]            req,
   output logic [NUNITS-1:0][AW-1:0]    addr,
   output logic [NUNITS-1:0]            addr_vld
);
   if (AW < 2) begin : g_bad_aw
      $error("dual_agu: AW must be at least 2");
   end
   if (NUNITS < 1) begin : g_bad_nu
      $error("dual_agu: NUNITS must be at least 1");
   end

   for (genvar u = 0; u < NUNITS; u++) begin : g_unit
      agu_unit #(.AW(AW), .HAS_REV(HAS_REV)) u_agu (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg_wr  (cfg_wr[u]),
         .cfg_mode(cfg_mode[u]),
         .cfg_base(cfg_base[u]),
         .cfg_step(cfg_step[u]),
         .cfg_lo  (cfg_lo[u]),
         .cfg_hi  (cfg_hi[u]),
         .req     (req[u]),
         .addr    (addr[u]),
         .addr_vld(addr_vld[u])
      );
   end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
   parameter int AW     = 16,
   parameter int NUNITS = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUNITS-1:0]         cfg_wr,
   input logic [NUNITS-1:0][1:0]    cfg_mode,
   input logic [NUNITS-1:0][AW-1:0] cfg_base,
   input logic [NUNITS-1:0]         req,
   input logic [NUNITS-1:0][AW-1:0] addr,
   input logic [NUNITS-1:0]         addr_vld
);
   for (genvar u = 0; u < NUNITS; u++) begin : g_u
      logic          wr_d;
      logic [1:0]    mode_s;
      logic [AW-1:0] base_s;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_d   <= 1'b0;
            mode_s <= 2'd0;
            base_s <= '0;
         end else begin
            wr_d <= cfg_wr[u];
            if (cfg_wr[u]) begin
               mode_s <= cfg_mode[u];
               base_s <= cfg_base[u];
            end
         end
      end

      p_vld_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (req[u] && !cfg_wr[u]) |=> addr_vld[u]);

      p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !addr_vld[u] |-> $stable(addr[u]));

      p_cfg_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_wr[u] |=> !addr_vld[u]);

      p_reload_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_d && req[u] && !cfg_wr[u] && mode_s != 2'd1) |=> (addr[u] == base_s));
   end
endmodule

bind dual_agu agu_chk #(.AW(AW), .NUNITS(NUNITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cfg_wr  (cfg_wr),
   .cfg_mode(cfg_mode),
   .cfg_base(cfg_base),
   .req     (req),
   .addr    (addr),
   .addr_vld(addr_vld)
);

// File: tb/tb_dual_agu.sv
`timescale 1ns/1ps
module tb_dual_agu;
   localparam int AW = 16;
   localparam int NU = 2;

   typedef struct packed {
      logic [1:0]  m;
      logic [15:0] base, step, lo, hi;
      logic [15:0] e0, e1, e2, e3;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 16'h0100, 16'h0004, 16'h0000, 16'h0000, 16'h0100, 16'h0104, 16'h0108, 16'h010C},
      '{2'd0, 16'h0002, 16'hFFFD, 16'h0000, 16'h0000, 16'h0002, 16'hFFFF, 16'hFFFC, 16'hFFF9},
      '{2'd1, 16'h0100, 16'h0004, 16'h0000, 16'h0000, 16'h0104, 16'h0108, 16'h010C, 16'h0110},
      '{2'd1, 16'h0010, 16'hFFF0, 16'h0000, 16'h0000, 16'h0000, 16'hFFF0, 16'hFFE0, 16'hFFD0},
      '{2'd2, 16'h0014, 16'h0003, 16'h0010, 16'h0017, 16'h0014, 16'h0017, 16'h0012, 16'h0015},
      '{2'd2, 16'h0011, 16'hFFFD, 16'h0010, 16'h0017, 16'h0011, 16'h0016, 16'h0013, 16'h0010},
      '{2'd2, 16'h0020, 16'h0001, 16'h0020, 16'h0022, 16'h0020, 16'h0021, 16'h0022, 16'h0020},
      '{2'd3, 16'h0000, 16'h0004, 16'h0000, 16'h0000, 16'h0000, 16'h0004, 16'h0002, 16'h0006},
      '{2'd3, 16'h0000, 16'h0008, 16'h0000, 16'h0000, 16'h0000, 16'h0008, 16'h0004, 16'h000C},
      '{2'd3, 16'h0006, 16'h0004, 16'h0000, 16'h0000, 16'h0006, 16'h0001, 16'h0005, 16'h0003}
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic [NU-1:0]         cfg_wr = '0;
   logic [NU-1:0][1:0]    cfg_mode = '0;
   logic [NU-1:0][AW-1:0] cfg_base = '0, cfg_step = '0, cfg_lo = '0, cfg_hi = '0;
   logic [NU-1:0]         req = '0;
   logic [NU-1:0][AW-1:0] addr;
   logic [NU-1:0]         addr_vld;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   dual_agu #(.AW(AW), .NUNITS(NU)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
      .cfg_base(cfg_base), .cfg_step(cfg_step), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
      .req(req), .addr(addr), .addr_vld(addr_vld)
   );

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic string mode_tag(input logic [1:0] m);
      case (m)
         2'd0:    return "R2";
         2'd1:    return "R3";
         2'd2:    return "R4 R5";
         default: return "R6";
      endcase
   endfunction

   task automatic set_cfg(input int u, input logic [1:0] m, input logic [AW-1:0] b,
                          input logic [AW-1:0] s, input logic [AW-1:0] l, input logic [AW-1:0] h);
      cfg_mode[u] = m; cfg_base[u] = b; cfg_step[u] = s; cfg_lo[u] = l; cfg_hi[u] = h;
   endtask

   task automatic configure(input int u, input logic [1:0] m, input logic [AW-1:0] b,
                            input logic [AW-1:0] s, input logic [AW-1:0] l, input logic [AW-1:0] h);
      @(negedge clk);
      set_cfg(u, m, b, s, l, h);
      cfg_wr[u] = 1'b1;
      @(negedge clk);
      cfg_wr[u] = 1'b0;
   endtask

   task automatic step_one(input int u);
      req[u] = 1'b1;
      @(negedge clk);
      req[u] = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(4.0 * 200000);
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1", addr[0], '0);
      chk("R1", addr[1], '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {15'd0, addr_vld[0]}, 16'd0);
      chk("R1", {15'd0, addr_vld[1]}, 16'd0);

      // Vector table, alternating channels
      for (int i = 0; i < NV; i++) begin
         int u;
         logic [AW-1:0] ex [4];
         u = i % 2;
         ex[0] = VEC[i].e0; ex[1] = VEC[i].e1; ex[2] = VEC[i].e2; ex[3] = VEC[i].e3;
         configure(u, VEC[i].m, VEC[i].base, VEC[i].step, VEC[i].lo, VEC[i].hi);
         for (int k = 0; k < 4; k++) begin
            step_one(u);
            chk(mode_tag(VEC[i].m), addr[u], ex[k]);
         end
         // R10: valid drops one cycle after the last request
         @(negedge clk);
         chk("R10", {15'd0, addr_vld[u]}, 16'd0);
         chk("R10", addr[u], ex[3]);
      end

      // R9: both channels step in the same cycle
      configure(0, 2'd0, 16'h0200, 16'h0002, 16'h0, 16'h0);
      configure(1, 2'd1, 16'h0300, 16'hFFFF, 16'h0, 16'h0);
      req = 2'b11;
      @(negedge clk);
      req = 2'b00;
      chk("R9", addr[0], 16'h0200);
      chk("R9", addr[1], 16'h02FF);
      chk("R9", {14'd0, addr_vld}, 16'h0003);
      // R10: idle cycle holds addresses
      @(negedge clk);
      chk("R10", {14'd0, addr_vld}, 16'h0000);
      chk("R10", addr[0], 16'h0200);
      // R9: lone request on channel 1 leaves channel 0 alone
      step_one(1);
      chk("R9", addr[1], 16'h02FE);
      chk("R9", addr[0], 16'h0200);
      chk("R9", {15'd0, addr_vld[0]}, 16'd0);

      // R8: configuration write and request collide on channel 0
      set_cfg(0, 2'd0, 16'h0500, 16'h0002, 16'h0, 16'h0);
      cfg_wr[0] = 1'b1;
      req[0] = 1'b1;
      @(negedge clk);
      cfg_wr[0] = 1'b0;
      req[0] = 1'b0;
      chk("R8", {15'd0, addr_vld[0]}, 16'd0);
      chk("R8", addr[0], 16'h0200);
      // R7: next request returns the reloaded initial address
      step_one(0);
      chk("R7", addr[0], 16'h0500);
      step_one(0);
      chk("R7", addr[0], 16'h0502);
      // R7: reload in update-before-use mode on channel 1
      configure(1, 2'd1, 16'h0040, 16'h0010, 16'h0, 16'h0);
      step_one(1);
      chk("R7", addr[1], 16'h0050);

      finish_run();
   end
endmodule